// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

The block drives a three-phase voltage-source inverter plus one spare leg. A 16-bit timebase counts up from zero to a programmed half-period value and back down, so every switching period is symmetric about its start. Each of four channels holds a signed duty word. The duty word is compared against the timebase to form a centered pulse. That pulse is split into a high-side and a low-side drive, and a programmable guard interval separates the two. This gives eight drive outputs in all.

Software loads settings through a small write port. New period, guard and duty values are held in shadow registers. They move into the working set at each period start, or also at the period midpoint when double-update is selected. A polarity bit inverts all eight drives. The block emits a one-cycle pulse at each period start and can optionally restart its period from an external pulse. An active-low trip input forces every drive to its inactive level at once, with no clock edge needed. The trip stays latched until software releases it.

Top module: `pwm3ph`

## Requirements
- R1: With the run bit (control bit 0) set and half-period P written at address 0 (2 <= P <= 65533), `syncOut` is a one-cycle pulse issued once every 2*P clock cycles.
- R2: Duty words at addresses 2..5 (channels 0..3) are signed. With T = ((duty + 32768) * (P + 2)) >> 16 and 1 <= T <= P, the raw high interval lasts 2*T-1 cycles per period. The active high-side time is that interval minus the guard count G (address 1), or zero if the interval is not longer than G.
- R3: A duty word whose T exceeds P (for example 32767) keeps the high side active and the low side inactive for the whole period. A word giving T = 0 (-32768 or -32767) keeps the high side inactive and the low side active for the whole period.
- R4: The low side is active for the complement of the raw interval minus G cycles, because each drive turns on only G cycles after the other turns off. The high and low drives of one channel are never active together.
- R5: With control bit 1 clear, a written duty word takes effect only at the next period start.
- R6: With control bit 1 set, a written duty word also takes effect at the period midpoint.
- R7: Control bit 2 set makes all eight drives active-low, and the inactive level becomes 1.
- R8: With control bit 3 set, a rising edge on `syncIn` restarts the period, and `syncOut` pulses within 8 cycles. With the bit clear, `syncIn` has no effect.
- R9: `shdnN` low forces all eight drives to the inactive level with no clock edge.
- R10: After `shdnN` returns high, the drives stay inactive until control is written with bit 4 set while the pin is high. They then resume at the next period start. Writing bit 4 while the pin is low has no effect.
- R11: After reset, and whenever the run bit is clear, all drives sit at the inactive level and `syncOut` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 16 | Register write data |
| syncIn | input | 1 | External period restart pulse |
| shdnN | input | 1 | Asynchronous active-low trip |
| syncOut | output | 1 | Period start pulse |
| pwmHi | output | 4 | High-side drives, channels 0..3 |
| pwmLo | output | 4 | Low-side drives, channels 0..3 |

## Verification
Two events can land in the same cycle. One is a shadow-to-working load at a period start or midpoint, which decides when a new duty word appears at the drives. The other is the trip or trip-release path, which also acts at a period start. The bench writes a full-on duty word just after a period-start pulse and judges whether the high side turns on before the next start, in single mode and in double mode. It also releases a latched trip and checks that the drives stay inactive up to the period-start pulse and come back right after it. The trip itself is asserted between clock edges, and the drives are sampled before the next edge.

// File: rtl/pwm3ph_pkg.sv
package pwm3ph_pkg;

  // strobes from the timebase control to the register datapath
  typedef struct packed {
    logic loadAll;   // move period, guard and duty shadows to working set
    logic loadDuty;  // move duty shadows only
  } pwmStb_t;

endpackage

// File: rtl/pwm3ph_deadband.sv
module pwm3ph_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hIn,
  input  logic [DT_W-1:0] guard,
  output logic            hiOn,
  output logic            loOn
);

  logic            prevH;
  logic [DT_W-1:0] dtCnt;
  logic            settled;

  // the level has held long enough to switch the incoming side on
  assign settled = (dtCnt >= guard);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevH <= 1'b0;
      dtCnt <= '0;
      hiOn  <= 1'b0;
      loOn  <= 1'b0;
    end else begin
      prevH <= hIn;
      if (hIn != prevH) begin
        dtCnt <= '0;
      end else if (dtCnt < guard) begin
        dtCnt <= dtCnt + 1'b1;
      end
      hiOn <= prevH & settled;
      loOn <= ~prevH & settled;
    end
  end

endmodule

// File: rtl/pwm3ph_ctrl.sv
module pwm3ph_ctrl
  import pwm3ph_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             dbl,
  input  logic             ext,
  input  logic [CNT_W-1:0] perAct,
  input  logic             syncIn,
  input  logic             shdnN,
  input  logic             clrReq,
  output logic [CNT_W-1:0] cnt,
  output pwmStb_t          stb,
  output logic             syncOut,
  output logic             offAll,
  output logic             shutLatch
);

  logic up;
  logic perStart;
  logic midPt;
  logic syncMeta, syncS, syncD;
  logic syncEdge;
  logic shdnMeta, shdnS;
  logic clrPend;

  // external restart pulse: two-stage synchronizer and rising-edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncMeta <= 1'b0;
      syncS    <= 1'b0;
      syncD    <= 1'b0;
      shdnMeta <= 1'b1;
      shdnS    <= 1'b1;
    end else begin
      syncMeta <= syncIn;
      syncS    <= syncMeta;
      syncD    <= syncS;
      shdnMeta <= shdnN;
      shdnS    <= shdnMeta;
    end
  end

  assign syncEdge = syncS & ~syncD;

  // up/down timebase: 0,1..P,P-1..1, then 0 again
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (!en) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (ext && syncEdge) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (up) begin
      if (cnt >= perAct) begin
        cnt <= perAct - 1'b1;
        up  <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (cnt <= CNT_W'(1)) begin
        cnt <= '0;
        up  <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign perStart = en & up & (cnt == '0);
  assign midPt    = en & up & (cnt >= perAct);

  assign stb.loadAll  = perStart | ~en;
  assign stb.loadDuty = perStart | ~en | (dbl & midPt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncOut <= 1'b0;
    else       syncOut <= perStart;
  end

  // release request is only honoured while the trip pin reads high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clrPend <= 1'b0;
    end else if (!shdnS) begin
      clrPend <= 1'b0;
    end else if (clrReq) begin
      clrPend <= 1'b1;
    end else if (!shutLatch) begin
      clrPend <= 1'b0;
    end
  end

  // trip latch: set at once by the pin, cleared only at a period start
  always_ff @(posedge clk or negedge rstN or negedge shdnN) begin
    if (!rstN) begin
      shutLatch <= 1'b0;
    end else if (!shdnN) begin
      shutLatch <= 1'b1;
    end else if (clrPend && shdnS && (perStart || !en)) begin
      shutLatch <= 1'b0;
    end
  end

  assign offAll = shutLatch | ~shdnN | ~en;

endmodule

// File: rtl/pwm3ph_dp.sv
module pwm3ph_dp
  import pwm3ph_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 8,
  parameter int NCH    = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [CNT_W-1:0]  cnt,
  input  pwmStb_t           stb,
  input  logic              offAll,
  output logic [CNT_W-1:0]  perAct,
  output logic              enBit,
  output logic              dblBit,
  output logic              polBit,
  output logic              extBit,
  output logic              clrReq,
  output logic [NCH-1:0]    pwmHi,
  output logic [NCH-1:0]    pwmLo
);

  localparam int THR_W  = CNT_W + 1;
  localparam int PROD_W = 2 * CNT_W + 1;
  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DT   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NCH + 2);
  localparam logic [CNT_W-1:0]  SIGN   = CNT_W'(1) << (CNT_W - 1);

  logic [CNT_W-1:0] perShd;
  logic [DT_W-1:0]  dtShd, dtAct;
  logic             ctrlWr;
  logic [NCH-1:0]   hiOn, loOn;
  logic [PROD_W-1:0] perMul;

  assign ctrlWr = wrEn && (wrAddr == A_CTRL);
  assign clrReq = ctrlWr && wrData[4];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perShd <= CNT_W'(100);
      dtShd  <= '0;
      enBit  <= 1'b0;
      dblBit <= 1'b0;
      polBit <= 1'b0;
      extBit <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == A_PER) perShd <= wrData;
      if (wrAddr == A_DT)  dtShd  <= wrData[DT_W-1:0];
      if (ctrlWr) begin
        enBit  <= wrData[0];
        dblBit <= wrData[1];
        polBit <= wrData[2];
        extBit <= wrData[3];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perAct <= CNT_W'(100);
      dtAct  <= '0;
    end else if (stb.loadAll) begin
      perAct <= perShd;
      dtAct  <= dtShd;
    end
  end

  // period plus two, widened for the duty scaling product
  assign perMul = PROD_W'({1'b0, perAct}) + PROD_W'(2);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(i + 2);

    logic [CNT_W-1:0]  dutyShd, dutyAct;
    logic [PROD_W-1:0] offMul;
    logic [THR_W-1:0]  thr;
    logic              hReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dutyShd <= '0;
      end else if (wrEn && (wrAddr == A_DUTY)) begin
        dutyShd <= wrData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dutyAct <= '0;
      end else if (stb.loadDuty) begin
        dutyAct <= dutyShd;
      end
    end

    // signed duty to offset binary, scaled into the count range
    assign offMul = PROD_W'(dutyAct ^ SIGN);
    assign thr    = THR_W'((offMul * perMul) >> CNT_W);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hReg <= 1'b0;
      else       hReg <= ({1'b0, cnt} < thr);
    end

    pwm3ph_deadband #(.DT_W(DT_W)) i_db (
      .clk  (clk),
      .rstN (rstN),
      .hIn  (hReg),
      .guard(dtAct),
      .hiOn (hiOn[i]),
      .loOn (loOn[i])
    );
  end

  // trip and idle paths are combinational so no clock edge is needed
  assign pwmHi = offAll ? {NCH{polBit}} : (hiOn ^ {NCH{polBit}});
  assign pwmLo = offAll ? {NCH{polBit}} : (loOn ^ {NCH{polBit}});

endmodule

// File: rtl/pwm3ph.sv
module pwm3ph
  import pwm3ph_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 8,
  parameter int NCH    = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              syncIn,
  input  logic              shdnN,
  output logic              syncOut,
  output logic [NCH-1:0]    pwmHi,
  output logic [NCH-1:0]    pwmLo
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] perAct;
  pwmStb_t          stb;
  logic             enBit, dblBit, polBit, extBit;
  logic             clrReq, offAll, shutLatch;

  pwm3ph_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .en       (enBit),
    .dbl      (dblBit),
    .ext      (extBit),
    .perAct   (perAct),
    .syncIn   (syncIn),
    .shdnN    (shdnN),
    .clrReq   (clrReq),
    .cnt      (cnt),
    .stb      (stb),
    .syncOut  (syncOut),
    .offAll   (offAll),
    .shutLatch(shutLatch)
  );

  pwm3ph_dp #(
    .CNT_W (CNT_W),
    .DT_W  (DT_W),
    .NCH   (NCH),
    .ADDR_W(ADDR_W)
  ) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .cnt   (cnt),
    .stb   (stb),
    .offAll(offAll),
    .perAct(perAct),
    .enBit (enBit),
    .dblBit(dblBit),
    .polBit(polBit),
    .extBit(extBit),
    .clrReq(clrReq),
    .pwmHi (pwmHi),
    .pwmLo (pwmLo)
  );

endmodule

// File: rtl/pwm3ph_chk.sv
module pwm3ph_chk #(
  parameter int CNT_W = 16,
  parameter int NCH   = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             shdnN,
  input logic             syncOut,
  input logic [NCH-1:0]   pwmHi,
  input logic [NCH-1:0]   pwmLo,
  input logic             polBit,
  input logic             enBit,
  input logic             shutLatch,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] perAct
);

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pwmHi ^ {NCH{polBit}}) & (pwmLo ^ {NCH{polBit}})) == '0);

  // R9
  trip_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shdnN |-> (pwmHi == {NCH{polBit}} && pwmLo == {NCH{polBit}}));

  // R10
  latch_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    shutLatch |-> (pwmHi == {NCH{polBit}} && pwmLo == {NCH{polBit}}));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= perAct);

  // R1
  sync_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncOut |=> !syncOut);

  // R11
  idle_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enBit && !$past(enBit)) |-> !syncOut);

endmodule

bind pwm3ph pwm3ph_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .shdnN    (shdnN),
  .syncOut  (syncOut),
  .pwmHi    (pwmHi),
  .pwmLo    (pwmLo),
  .polBit   (polBit),
  .enBit    (enBit),
  .shutLatch(shutLatch),
  .cnt      (cnt),
  .perAct   (perAct)
);

// File: tb/test_pwm3ph.sv
`timescale 1ns/1ps
module test_pwm3ph;

  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        syncIn = 1'b0;
  logic        shdnN = 1'b1;
  logic        syncOut;
  logic [NCH-1:0] pwmHi, pwmLo;

  int nRun = 0;
  int nFail = 0;
  int cyc = 0;
  bit curPol = 1'b0;
  int curP = 100;
  int curDT = 0;
  int hiCnt [NCH];
  int loCnt [NCH];
  int ovCnt;

  pwm3ph i_pwm3ph (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .syncIn(syncIn), .shdnN(shdnN), .syncOut(syncOut), .pwmHi(pwmHi), .pwmLo(pwmLo)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a[2:0]; wrData = d[15:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setCtrl(input bit en, input bit dbl, input bit pol, input bit ext, input bit clr);
    curPol = pol;
    wr(6, {27'd0, clr, ext, pol, dbl, en});
  endtask

  function automatic int expThr(input int d, input int p);
    longint prod;
    prod = longint'(d + 32768) * longint'(p + 2);
    return int'(prod >>> 16);
  endfunction

  function automatic int expHi(input int t, input int p, input int dt);
    int len;
    if (t == 0) return 0;
    if (t > p) return 2 * p;
    len = 2 * t - 1;
    return (len > dt) ? len - dt : 0;
  endfunction

  function automatic int expLo(input int t, input int p, input int dt);
    int len;
    if (t == 0) return 2 * p;
    if (t > p) return 0;
    len = 2 * p - (2 * t - 1);
    return (len > dt) ? len - dt : 0;
  endfunction

  // count active cycles of each drive over one full period
  task automatic measure();
    for (int i = 0; i < NCH; i++) begin hiCnt[i] = 0; loCnt[i] = 0; end
    ovCnt = 0;
    for (int k = 0; k < 2 * curP; k++) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
        if (pwmHi[i] ^ curPol) hiCnt[i]++;
        if (pwmLo[i] ^ curPol) loCnt[i]++;
        if ((pwmHi[i] ^ curPol) && (pwmLo[i] ^ curPol)) ovCnt++;
      end
    end
  endtask

  task automatic waitSync(input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!syncOut && n < lim);
  endtask

  initial begin
    int seedDummy;
    int d [NCH];
    int n, t;
    bit seen;
    seedDummy = $urandom(32'd5021);

    tick(3);
    rstN = 1'b1;
    tick(2);
    // R11 reset state
    check(pwmHi == '0 && pwmLo == '0, "R11 reset drives", {pwmHi, pwmLo}, 0);
    check(syncOut == 1'b0, "R11 reset sync", syncOut, 0);

    // R1 period of the start pulse
    curP = 50; curDT = 3;
    wr(0, curP); wr(1, curDT);
    setCtrl(1, 0, 0, 0, 0);
    tick(300);
    waitSync(400, n);
    waitSync(400, n);
    check(n == 2 * curP, "R1 sync interval", n, 2 * curP);
    curP = 37;
    wr(0, curP);
    tick(300);
    waitSync(400, n);
    waitSync(400, n);
    check(n == 2 * curP, "R1 sync interval new period", n, 2 * curP);

    // R2 / R4 random duty patterns
    for (int it = 0; it < 6; it++) begin
      curP  = $urandom_range(200, 40);
      curDT = $urandom_range(7, 0);
      wr(0, curP); wr(1, curDT);
      for (int i = 0; i < NCH; i++) begin
        d[i] = int'($urandom_range(48000, 0)) - 24000;
        wr(2 + i, d[i]);
      end
      tick(1000);
      measure();
      for (int i = 0; i < NCH; i++) begin
        t = expThr(d[i], curP);
        check(hiCnt[i] == expHi(t, curP, curDT), "R2 high-side on-time", hiCnt[i], expHi(t, curP, curDT));
        check(loCnt[i] == expLo(t, curP, curDT), "R4 low-side on-time", loCnt[i], expLo(t, curP, curDT));
      end
      check(ovCnt == 0, "R4 overlap", ovCnt, 0);
    end

    // R3 extremes
    curP = 50; curDT = 3;
    wr(0, curP); wr(1, curDT);
    wr(2, 32767); wr(3, -32768); wr(4, -32767); wr(5, 32766);
    tick(600);
    measure();
    check(hiCnt[0] == 2 * curP && loCnt[0] == 0, "R3 full on ch0", hiCnt[0], 2 * curP);
    check(hiCnt[1] == 0 && loCnt[1] == 2 * curP, "R3 full off ch1", hiCnt[1], 0);
    check(hiCnt[2] == 0 && loCnt[2] == 2 * curP, "R3 full off ch2", hiCnt[2], 0);
    check(hiCnt[3] == 2 * curP && loCnt[3] == 0, "R3 full on ch3", hiCnt[3], 2 * curP);

    // R7 polarity: raw pin levels inverted
    setCtrl(1, 0, 1, 0, 0);
    tick(10);
    n = 0; t = 0;
    for (int k = 0; k < 2 * curP; k++) begin
      @(negedge clk);
      if (pwmHi[0]) n++;
      if (pwmLo[0]) t++;
    end
    check(n == 0, "R7 active-low high side raw ones", n, 0);
    check(t == 2 * curP, "R7 active-low low side raw ones", t, 2 * curP);
    setCtrl(0, 0, 1, 0, 0);
    tick(3);
    check(pwmHi == '1 && pwmLo == '1, "R11 idle level with inverted polarity", {pwmHi, pwmLo}, 255);
    tick(2 * curP + 5);
    check(syncOut == 1'b0, "R11 no sync while idle", syncOut, 0);

    // R5 / R6 update timing
    for (int mode = 0; mode < 2; mode++) begin
      curP = 60; curDT = 0;
      wr(0, curP); wr(1, 0); wr(2, -32768);
      setCtrl(1, mode[0], 0, 0, 0);
      tick(400);
      waitSync(400, n);
      wr(2, 32767);
      seen = 1'b0;
      for (int k = 0; k < curP + 10; k++) begin
        @(negedge clk);
        if (pwmHi[0]) seen = 1'b1;
      end
      if (mode == 0) check(!seen, "R5 single update holds until period start", seen, 0);
      else           check(seen,  "R6 double update loads at midpoint", seen, 1);
      tick(2 * curP);
      check(pwmHi[0] == 1'b1, "R5 new duty after period start", pwmHi[0], 1);
    end

    // R8 external restart
    curP = 100;
    wr(0, curP);
    setCtrl(1, 0, 0, 1, 0);
    tick(400);
    waitSync(400, n);
    tick(50);
    syncIn = 1'b1; tick(2); syncIn = 1'b0;
    waitSync(40, n);
    check(n <= 8 && syncOut, "R8 restart latency", n, 8);
    setCtrl(1, 0, 0, 0, 0);
    waitSync(400, n);
    tick(50);
    syncIn = 1'b1; tick(2); syncIn = 1'b0;
    waitSync(20, n);
    check(!syncOut, "R8 restart ignored when disabled", syncOut, 0);

    // R9 / R10 trip
    curP = 40; curDT = 2;
    wr(0, curP); wr(1, curDT); wr(2, 0);
    tick(300);
    n = 0;
    while (!pwmHi[0] && n < 200) begin @(negedge clk); n++; end
    #0.5 shdnN = 1'b0;
    #1.0;
    check(pwmHi == '0 && pwmLo == '0, "R9 drives off before any clock edge", {pwmHi, pwmLo}, 0);
    tick(5);
    shdnN = 1'b1;
    n = 0;
    for (int k = 0; k < 3 * 2 * curP; k++) begin
      @(negedge clk);
      if (pwmHi != '0 || pwmLo != '0) n++;
    end
    check(n == 0, "R10 drives stay off after pin release", n, 0);
    shdnN = 1'b0;
    tick(5);
    setCtrl(1, 0, 0, 0, 1);
    tick(5);
    shdnN = 1'b1;
    n = 0;
    for (int k = 0; k < 2 * curP + 10; k++) begin
      @(negedge clk);
      if (pwmHi != '0 || pwmLo != '0) n++;
    end
    check(n == 0, "R10 release written while pin low is ignored", n, 0);
    setCtrl(1, 0, 0, 0, 1);
    n = 0; t = 0;
    while (!syncOut && t < 4 * curP) begin
      if (pwmHi != '0 || pwmLo != '0) n++;
      @(negedge clk);
      t++;
    end
    check(n == 0, "R10 drives off until period start", n, 0);
    seen = 1'b0;
    for (int k = 0; k < curDT + 8; k++) begin
      if (pwmHi[0]) seen = 1'b1;
      @(negedge clk);
    end
    check(seen, "R10 drives resume at period start", seen, 1);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule